// File: doc/BRIEF.md
# Three-Phase Complementary PWM Generator

This block drives three motor phases, each with a high-side (positive) output and a low-side (negative) output. Two up/down triangle counters run in lockstep, one offset above the other by the dead-time value. Each phase compares its duty value against both counters. The positive output turns on only when the duty is below both counter values. The negative output turns on only when the duty is below neither. Between the two outputs there is therefore a gap of at least the dead time on every edge.

Software first stops the counters and writes the configuration. It then preloads the upper counter with the dead time and the lower counter with zero, and starts both with one write. While the counters run, new duty and carrier values go into buffer registers. The block copies them into the active registers only when the lower counter turns at its crest or its trough. A bypass bit makes each negative output the exact complement of its positive output, which removes the dead-time gap. The register port has no back-pressure: every write is taken in the cycle it is presented. Writes to registers that are locked while running are dropped.

Top module: `cpwm_gen`

## Requirements
- R1: After reset the counters are stopped, every PWM pin is 0, `sync_tog` is 0, both levels are active-high (CFG reset value 0x3) and the output-enable mask is 0.
- R2: Address map: 0 RUN (bit 0); 1 DEAD; 2 HALF; 3 HALF buffer; 4 LIMIT; 5 LIMIT buffer; 6..8 active duty for phases 0..2; 9..11 duty buffers for phases 0..2; 12 CFG; 13 output-enable mask; 14 upper-counter preload; 15 lower-counter preload. While running, writes to DEAD, HALF, LIMIT, the active duties, CFG and the preloads have no effect.
- R3: A single write of 1 to RUN starts both counters in the same cycle. While running, the upper counter stays exactly DEAD above the lower counter.
- R4: The lower counter steps by one every cycle from 0 up to HALF and back down to 0, so the carrier period is 2*HALF cycles. The upper counter turns at LIMIT and at DEAD.
- R5: The positive output of a phase is active while its duty is below both counter values. This gives 2*HALF-2*duty-1 active cycles per period when duty < HALF, and none otherwise.
- R6: Without bypass, the negative output is active while the duty is not below the upper counter. The two outputs of a phase are never active together, and the positive output never turns on in the cycle right after the negative output was active.
- R7: The buffer values (HALF, LIMIT, duties) move to the active registers only in the cycle where the lower counter turns at its crest or its trough. A duty-buffer write does not change the outputs before that turn.
- R8: With CFG bit 3 set (bypass), each negative output is the complement of its positive output.
- R9: CFG bit 0 sets the active level of the positive group and CFG bit 1 sets the active level of the negative group (1 = active-high, 0 = active-low).
- R10: Mask bit i enables positive pin i and mask bit 3+i enables negative pin i. A disabled pin is held at 0.
- R11: With CFG bit 2 set, `sync_tog` inverts once per carrier period, in the cycle after the lower counter reaches its crest. With the bit clear it holds.
- R12: While stopped, every enabled pin sits at its inactive level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, taken every cycle |
| wr_addr | input | 4 | Register address |
| wr_data | input | CW | Register write data |
| pwm_p | output | 3 | Positive (high-side) outputs, one per phase |
| pwm_n | output | 3 | Negative (low-side) outputs, one per phase |
| sync_tog | output | 1 | Toggle output synchronized to the carrier period |

## Verification
The assertions rely on the inputs keeping to a valid setup. Both counters are preloaded with DEAD and 0 before each start. DEAD is at least 1 and HALF at least 1. LIMIT equals HALF plus DEAD, in both the active register and its buffer. Under those conditions the counter offset, the lockstep turning and the dead-time gap hold. The stimulus reconfigures through one fixed sequence that always follows these rules. That sequence stops the counters, writes DEAD, HALF and LIMIT together with equal buffers, writes matching active and buffered duties, preloads both counters, and then starts them. While running, only duty buffers and locked registers are written.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;
  localparam int ADDR_W = 4;
  localparam int NPH = 3;
  localparam int DUTY_BASE = 6;
  localparam int DBUF_BASE = 9;

  typedef enum logic [ADDR_W-1:0] {
    A_RUN      = 4'd0,
    A_DEAD     = 4'd1,
    A_HALF     = 4'd2,
    A_HALF_BUF = 4'd3,
    A_LIM      = 4'd4,
    A_LIM_BUF  = 4'd5,
    A_CFG      = 4'd12,
    A_OEN      = 4'd13,
    A_PRE_HI   = 4'd14,
    A_PRE_LO   = 4'd15
  } reg_addr_e;

  typedef struct packed {
    logic bypass;
    logic tog_en;
    logic lvl_n;
    logic lvl_p;
  } cfg_t;
endpackage

// File: rtl/cpwm_tri_cnt.sv
module cpwm_tri_cnt #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic [CW-1:0] lo,
  input  logic [CW-1:0] hi,
  output logic [CW-1:0] cnt,
  output logic          at_hi,
  output logic          at_lo
);
  logic up;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      up  <= 1'b1;
    end else if (load) begin
      cnt <= load_val;
      up  <= 1'b1;
    end else if (run) begin
      if (up) begin
        if (cnt >= hi) begin
          cnt <= cnt - 1'b1;
          up  <= 1'b0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else begin
        if (cnt <= lo) begin
          cnt <= cnt + 1'b1;
          up  <= 1'b1;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end

  assign at_hi = up && (cnt >= hi);
  assign at_lo = !up && (cnt <= lo);

  // R4: a running counter moves by exactly one each cycle
  assert_unit_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> (cnt == $past(cnt) + 1'b1) || (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/cpwm_regs.sv
module cpwm_regs import cpwm_pkg::*; #(
  parameter int CW = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [ADDR_W-1:0]      wr_addr,
  input  logic [CW-1:0]          wr_data,
  input  logic                   xfer,
  output logic                   run,
  output logic [CW-1:0]          dead,
  output logic [CW-1:0]          half,
  output logic [CW-1:0]          limit,
  output logic [NPH-1:0][CW-1:0] duty,
  output cfg_t                   cfg,
  output logic [2*NPH-1:0]       oen,
  output logic                   ld_hi,
  output logic                   ld_lo
);
  logic [CW-1:0]          half_b, lim_b;
  logic [NPH-1:0][CW-1:0] duty_b;
  logic                   stopped;

  assign stopped = !run;
  assign ld_hi = wr_en && stopped && (wr_addr == A_PRE_HI);
  assign ld_lo = wr_en && stopped && (wr_addr == A_PRE_LO);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run    <= 1'b0;
      dead   <= '0;
      half   <= '0;
      limit  <= '0;
      half_b <= '0;
      lim_b  <= '0;
      duty   <= '0;
      duty_b <= '0;
      cfg    <= '{bypass: 1'b0, tog_en: 1'b0, lvl_n: 1'b1, lvl_p: 1'b1};
      oen    <= '0;
    end else begin
      if (xfer) begin
        half  <= half_b;
        limit <= lim_b;
        duty  <= duty_b;
      end
      if (wr_en) begin
        case (wr_addr)
          A_RUN:      run <= wr_data[0];
          A_DEAD:     if (stopped) dead <= wr_data;
          A_HALF:     if (stopped) half <= wr_data;
          A_HALF_BUF: half_b <= wr_data;
          A_LIM:      if (stopped) limit <= wr_data;
          A_LIM_BUF:  lim_b <= wr_data;
          A_CFG:      if (stopped) cfg <= cfg_t'(wr_data[3:0]);
          A_OEN:      oen <= wr_data[2*NPH-1:0];
          default:    ;
        endcase
        for (int i = 0; i < NPH; i++) begin
          if (stopped && (wr_addr == ADDR_W'(DUTY_BASE + i))) duty[i] <= wr_data;
          if (wr_addr == ADDR_W'(DBUF_BASE + i)) duty_b[i] <= wr_data;
        end
      end
    end
  end

  // R7: active duties change while running only through a turn-point transfer
  assert_duty_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !xfer) |=> $stable(duty));
  // R2: locked settings keep their value while running
  assert_locked_R2: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> ($stable(dead) && $stable(cfg)));
endmodule

// File: rtl/cpwm_phase.sv
module cpwm_phase #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [CW-1:0] c_hi,
  input  logic [CW-1:0] c_lo,
  input  logic [CW-1:0] duty,
  input  logic          bypass,
  input  logic          lvl_p,
  input  logic          lvl_n,
  input  logic          en_p,
  input  logic          en_n,
  output logic          pin_p,
  output logic          pin_n
);
  logic over_hi, over_lo, act_p, act_n;

  always_comb begin
    over_hi = c_hi > duty;
    over_lo = c_lo > duty;
    act_p   = run && over_hi && over_lo;
    if (bypass) act_n = run && !(over_hi && over_lo);
    else        act_n = run && !over_hi && !over_lo;
    pin_p = en_p && (act_p ~^ lvl_p);
    pin_n = en_n && (act_n ~^ lvl_n);
  end

  // R6: the positive side never turns on straight after the negative side
  assert_dead_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!bypass && $rose(act_p) && $stable(duty)) |-> $past(!act_n));
endmodule

// File: rtl/cpwm_gen.sv
module cpwm_gen import cpwm_pkg::*; #(
  parameter int CW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CW-1:0]     wr_data,
  output logic [NPH-1:0]    pwm_p,
  output logic [NPH-1:0]    pwm_n,
  output logic              sync_tog
);
  logic                   run, ld_hi, ld_lo, xfer;
  logic [CW-1:0]          dead, half, limit, c_hi, c_lo;
  logic [NPH-1:0][CW-1:0] duty;
  cfg_t                   cfg;
  logic [2*NPH-1:0]       oen;
  logic                   crest_hi, trough_hi, crest_lo, trough_lo;
  logic                   tog_q;

  cpwm_regs #(.CW(CW)) u_regs (
    .clk, .rst_n, .wr_en, .wr_addr, .wr_data, .xfer,
    .run, .dead, .half, .limit, .duty, .cfg, .oen, .ld_hi, .ld_lo
  );

  cpwm_tri_cnt #(.CW(CW)) u_cnt_hi (
    .clk, .rst_n, .run, .load(ld_hi), .load_val(wr_data),
    .lo(dead), .hi(limit), .cnt(c_hi), .at_hi(crest_hi), .at_lo(trough_hi)
  );

  cpwm_tri_cnt #(.CW(CW)) u_cnt_lo (
    .clk, .rst_n, .run, .load(ld_lo), .load_val(wr_data),
    .lo('0), .hi(half), .cnt(c_lo), .at_hi(crest_lo), .at_lo(trough_lo)
  );

  assign xfer = run && (crest_lo || trough_lo);

  for (genvar i = 0; i < NPH; i++) begin : g_phase
    cpwm_phase #(.CW(CW)) u_phase (
      .clk, .rst_n, .run, .c_hi, .c_lo, .duty(duty[i]),
      .bypass(cfg.bypass), .lvl_p(cfg.lvl_p), .lvl_n(cfg.lvl_n),
      .en_p(oen[i]), .en_n(oen[NPH+i]),
      .pin_p(pwm_p[i]), .pin_n(pwm_n[i])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tog_q <= 1'b0;
    else if (run && cfg.tog_en && crest_lo) tog_q <= !tog_q;
  end
  assign sync_tog = tog_q;

  // R3: counters hold their offset and turn in the same cycle
  assert_offset_R3: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> ((c_hi - c_lo) == dead));
  assert_turn_sync_R3: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> ((crest_hi == crest_lo) && (trough_hi == trough_lo)));
  // R11: the toggle output moves only after a crest
  assert_tog_crest_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(tog_q) |-> $past(run && crest_lo));
endmodule

// File: tb/cpwm_gen_bench.sv
module cpwm_gen_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 16;
  localparam int NV = 5;
  // columns: half, dead, duty0, duty1, duty2, bypass, lvl_p, lvl_n
  localparam int VEC [NV][8] = '{
    '{20, 3,  5, 10, 15, 0, 1, 1},
    '{16, 2,  0,  8, 16, 0, 1, 1},
    '{12, 4,  2,  6, 11, 0, 0, 1},
    '{10, 1,  3,  5,  7, 1, 1, 0},
    '{24, 5,  1, 20, 30, 0, 1, 1}
  };

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [CW-1:0] wr_data = '0;
  logic [2:0] pwm_p, pwm_n;
  logic sync_tog;
  int checks = 0, fails = 0;
  int cp [3];
  int cn [3];
  int tog_moves;

  always #(CLK_PERIOD/2) clk = ~clk;

  cpwm_gen #(.CW(CW)) u_cpwm_gen (
    .clk, .rst_n, .wr_en, .wr_addr, .wr_data, .pwm_p, .pwm_n, .sync_tog
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int tri_val(int h, int k);
    return (k <= h) ? k : 2*h - k;
  endfunction

  function automatic int exp_pos(int h, int d);
    int n = 0;
    for (int k = 0; k < 2*h; k++) if (tri_val(h, k) > d) n++;
    return n;
  endfunction

  function automatic int exp_neg(int h, int t, int d, int byp);
    int n = 0;
    if (byp != 0) return 2*h - exp_pos(h, d);
    for (int k = 0; k < 2*h; k++) if (tri_val(h, k) + t <= d) n++;
    return n;
  endfunction

  task automatic wr(input int a, input int d);
    wr_en = 1'b1; wr_addr = 4'(a); wr_data = CW'(d);
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic setup(input int h, input int t, input int d0, input int d1,
                       input int d2, input int cfgv, input int mask);
    wr(0, 0);
    wr(1, t); wr(2, h); wr(3, h); wr(4, h + t); wr(5, h + t);
    wr(6, d0); wr(7, d1); wr(8, d2); wr(9, d0); wr(10, d1); wr(11, d2);
    wr(12, cfgv); wr(13, mask); wr(14, t); wr(15, 0);
    wr(0, 1);
  endtask

  task automatic measure(input int h, input logic lp, input logic ln);
    logic prev;
    for (int i = 0; i < 3; i++) begin cp[i] = 0; cn[i] = 0; end
    tog_moves = 0;
    prev = sync_tog;
    for (int k = 0; k < 2*h; k++) begin
      @(negedge clk);
      for (int i = 0; i < 3; i++) begin
        if (pwm_p[i] == lp) cp[i]++;
        if (pwm_n[i] == ln) cn[i]++;
      end
      if (sync_tog != prev) tog_moves++;
      prev = sync_tog;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 pwm_p in reset", int'(pwm_p), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 pwm_p after reset", int'(pwm_p), 0);
    chk("R1 pwm_n after reset", int'(pwm_n), 0);
    chk("R1 sync_tog after reset", int'(sync_tog), 0);

    // vector table: full periods under several configurations
    for (int v = 0; v < NV; v++) begin
      int cfgv;
      cfgv = VEC[v][5]*8 + VEC[v][7]*2 + VEC[v][6];
      setup(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4], cfgv, 63);
      measure(VEC[v][0], VEC[v][6][0], VEC[v][7][0]);
      for (int i = 0; i < 3; i++) begin
        chk($sformatf("R5 R4 R9 vec%0d pos ph%0d", v, i), cp[i],
            exp_pos(VEC[v][0], VEC[v][2+i]));
        chk($sformatf("%s R9 vec%0d neg ph%0d", (VEC[v][5] != 0) ? "R8" : "R6 R3", v, i),
            cn[i], exp_neg(VEC[v][0], VEC[v][1], VEC[v][2+i], VEC[v][5]));
      end
    end

    // R10: mask clears positive pin of phase 1 only
    setup(20, 3, 5, 10, 15, 3, 61);
    measure(20, 1'b1, 1'b1);
    chk("R10 masked pos ph1", cp[1], 0);
    chk("R10 unmasked neg ph1", cn[1], exp_neg(20, 3, 10, 0));

    // R2: active duty and dead writes while running are dropped
    wr(6, 19);
    wr(1, 9);
    measure(20, 1'b1, 1'b1);
    chk("R2 duty write while running pos ph0", cp[0], exp_pos(20, 5));
    chk("R2 dead write while running neg ph0", cn[0], exp_neg(20, 3, 5, 0));

    // R11: toggle once per period when enabled, hold when disabled
    setup(20, 3, 5, 10, 15, 7, 63);
    measure(20, 1'b1, 1'b1);
    chk("R11 toggle enabled moves", tog_moves, 1);
    setup(20, 3, 5, 10, 15, 3, 63);
    measure(20, 1'b1, 1'b1);
    chk("R11 toggle disabled moves", tog_moves, 0);

    // R7: buffered duty waits for the crest
    setup(20, 3, 10, 10, 10, 3, 63);
    repeat (3) @(negedge clk);
    wr(9, 2);
    @(negedge clk);
    chk("R7 pos ph0 before crest", int'(pwm_p[0]), 0);
    chk("R7 neg ph0 before crest", int'(pwm_n[0]), 1);
    repeat (30) @(negedge clk);
    chk("R7 pos ph0 after crest", int'(pwm_p[0]), 1);
    chk("R7 neg ph0 after crest", int'(pwm_n[0]), 0);

    // R12: stopping drives enabled pins to inactive level
    wr(0, 0);
    chk("R12 pwm_p stopped", int'(pwm_p), 0);
    chk("R12 pwm_n stopped", int'(pwm_n), 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule